// File: doc/BRIEF.md
# Remote-Control Carrier Pulse Generator

This block drives the single high-current output of a remote-control transmitter. Whenever the processor's port enable bit is set, it sends a periodic carrier whose period and high time are counted in oscillator clocks. A small mode register selects one of five fixed carrier shapes, or selects a static mode in which the pin simply follows the enable bit like an ordinary output port.

A slow-cycle option input stretches every period and every high time by a factor of eight, so the duty ratio is unchanged. Every period starts with its high phase. Releasing the enable bit parks the output low and returns the phase counter to zero, so the next burst starts with a complete pulse. A new mode value only takes effect at a period boundary, which means no pulse is ever cut short. The scale option is latched at the same boundaries.

Top module: `carrier_gen`

## Requirements
- R1: While `rst_ni` is low, `carrier_o` is 0 and the selected mode is 0. After reset, 0 stays the mode until a write is made.
- R2: Mode 0 (3-bit code 0) gives a 12-clock period: high for 4 clocks, then low for 8.
- R3: Mode code 1 gives an 8-clock period: high for 4 clocks, then low for 4.
- R4: Mode code 2 gives an 8-clock period: high for 2 clocks, then low for 6.
- R5: Mode code 3 gives an 11-clock period: high for 4 clocks, then low for 7.
- R6: Mode code 4 gives a 12-clock period: high for 3 clocks, then low for 9.
- R7: Mode codes 5, 6 and 7 send no carrier. In these modes `carrier_o` equals the `gate_i` value sampled at the previous clock edge.
- R8: When `slow_i` is 1, every period and every high time is 8 times longer (96, 64 or 88 clocks). The high phase still comes first.
- R9: When `gate_i` is 0 at a clock edge, `carrier_o` is 0 after that edge and the phase returns to zero. The first edge that samples `gate_i` at 1 drives the first high clock of a complete period.
- R10: A mode write (`mode_we_i` with `mode_wdata_i`) made during a carrier period takes effect only after the last clock of that period. A write made while `gate_i` is 0 or while a static mode is active takes effect at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 3 | Mode value to write |
| gate_i | input | 1 | Port enable bit from the processor |
| slow_i | input | 1 | Slow-cycle option, scales the timing by 8 |
| carrier_o | output | 1 | Carrier output pin, active high |

## Verification
The output is registered, so every result is due exactly one clock edge after the inputs that cause it. This holds for gate changes, carrier phases and static-mode levels alike. A mode write shows up on the pin one edge after the period boundary that follows it, or one edge after the write itself when the block is idle or static. The driver applies the inputs for one edge at the falling clock edge and queues the output level that the requirements predict for that edge. The monitor takes one entry from the queue 1 ns after each rising edge and compares it with the pin, so each expected value lines up with the edge that produces it.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned BASE_W = 4;

  typedef logic [MODE_W-1:0] mode_t;

  typedef struct packed {
    logic [BASE_W-1:0] period;
    logic [BASE_W-1:0] high;
    logic              is_static;
  } shape_t;

  function automatic shape_t base_shape(mode_t m);
    shape_t s;
    s.is_static = 1'b0;
    unique case (m)
      3'd0:    begin s.period = 4'd12; s.high = 4'd4; end
      3'd1:    begin s.period = 4'd8;  s.high = 4'd4; end
      3'd2:    begin s.period = 4'd8;  s.high = 4'd2; end
      3'd3:    begin s.period = 4'd11; s.high = 4'd4; end
      3'd4:    begin s.period = 4'd12; s.high = 4'd3; end
      default: begin s.period = 4'd1;  s.high = 4'd1; s.is_static = 1'b1; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/carrier_mode_reg.sv
module carrier_mode_reg
  import carrier_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  mode_t wdata_i,
  input  logic  boundary_i,
  input  logic  slow_i,
  output mode_t mode_o,
  output logic  slow_o
);
  mode_t pend_q, act_q, pend_d;
  logic  slow_q;

  assign pend_d = we_i ? wdata_i : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (boundary_i) begin
        act_q  <= pend_d;
        slow_q <= slow_i;
      end
    end
  end

  assign mode_o = act_q;
  assign slow_o = slow_q;
endmodule

// File: rtl/carrier_shape_lut.sv
module carrier_shape_lut
  import carrier_pkg::*;
#(
  parameter int unsigned SCALE_SHIFT = 3,
  localparam int unsigned CNT_W      = BASE_W + SCALE_SHIFT
) (
  input  mode_t            mode_i,
  input  logic             slow_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] high_o,
  output logic             is_static_o
);
  shape_t base;
  logic [CNT_W-1:0] p_ext, h_ext;

  always_comb begin
    base  = base_shape(mode_i);
    p_ext = CNT_W'(base.period);
    h_ext = CNT_W'(base.high);
  end

  generate
    if (SCALE_SHIFT == 0) begin : g_noscale
      assign period_o = p_ext;
      assign high_o   = h_ext;
    end else begin : g_scale
      assign period_o = slow_i ? (p_ext << SCALE_SHIFT) : p_ext;
      assign high_o   = slow_i ? (h_ext << SCALE_SHIFT) : h_ext;
    end
  endgenerate

  assign is_static_o = base.is_static;
endmodule

// File: rtl/carrier_phase_cnt.sv
module carrier_phase_cnt #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/carrier_gen.sv
module carrier_gen
  import carrier_pkg::*;
#(
  parameter int unsigned SCALE_SHIFT = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_we_i,
  input  logic [2:0]  mode_wdata_i,
  input  logic        gate_i,
  input  logic        slow_i,
  output logic        carrier_o
);
  localparam int unsigned CNT_W = BASE_W + SCALE_SHIFT;

  mode_t            mode_act;
  logic             slow_act;
  logic [CNT_W-1:0] period, high, cnt;
  logic             is_static, at_last, boundary, run, out_q;

  assign run      = gate_i && !is_static;
  assign boundary = !gate_i || is_static || at_last;

  carrier_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (mode_we_i),
    .wdata_i    (mode_wdata_i),
    .boundary_i (boundary),
    .slow_i     (slow_i),
    .mode_o     (mode_act),
    .slow_o     (slow_act)
  );

  carrier_shape_lut #(.SCALE_SHIFT(SCALE_SHIFT)) u_lut (
    .mode_i      (mode_act),
    .slow_i      (slow_act),
    .period_o    (period),
    .high_o      (high),
    .is_static_o (is_static)
  );

  carrier_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .period_i (period),
    .cnt_o    (cnt),
    .last_o   (at_last)
  );

  // high phase first, static modes mirror the gate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= gate_i && (is_static || (cnt < high));
  end

  assign carrier_o = out_q;
endmodule

// File: rtl/carrier_gen_chk.sv
module carrier_gen_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gate_i,
  input logic             carrier_o,
  input logic [2:0]       mode_act,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic             is_static,
  input logic             at_last
);
  assert_gate_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> !carrier_o);

  assert_rise_full_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_i) |=> carrier_o);

  assert_static_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && is_static) |=> carrier_o);

  assert_phase_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !is_static) |-> (cnt < period));

  assert_mode_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !is_static && !at_last) |=> $stable(mode_act));
endmodule

bind carrier_gen carrier_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gate_i    (gate_i),
  .carrier_o (carrier_o),
  .mode_act  (mode_act),
  .cnt       (cnt),
  .period    (period),
  .is_static (is_static),
  .at_last   (at_last)
);

// File: tb/carrier_gen_tb.sv
`timescale 1ns/1ps
module carrier_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       mode_we_i = 1'b0;
  logic [2:0] mode_wdata_i = 3'd0;
  logic       gate_i = 1'b0;
  logic       slow_i = 1'b0;
  logic       carrier_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  // reference state, built from the requirements
  int m_act = 0, m_pend = 0, m_ph = 0;
  bit m_slow = 1'b0;

  always #2.5 clk_i = ~clk_i;

  carrier_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i),
    .mode_wdata_i(mode_wdata_i), .gate_i(gate_i), .slow_i(slow_i),
    .carrier_o(carrier_o)
  );

  function automatic void shape(input int m, input bit s, output int p, output int h);
    case (m)
      0: begin p = 12; h = 4; end
      1: begin p = 8;  h = 4; end
      2: begin p = 8;  h = 2; end
      3: begin p = 11; h = 4; end
      4: begin p = 12; h = 3; end
      default: begin p = 0; h = 0; end
    endcase
    if (s) begin p = p * 8; h = h * 8; end
  endfunction

  task automatic step(input bit we, input int wd, input bit g, input bit s, input string tag);
    int nxt, p, h;
    bit e;
    @(negedge clk_i);
    mode_we_i = we; mode_wdata_i = 3'(wd); gate_i = g; slow_i = s;
    nxt = we ? wd : m_pend;
    if (!g) begin
      e = 1'b0; m_ph = 0; m_act = nxt; m_slow = s;
    end else if (m_act >= 5) begin
      e = 1'b1; m_ph = 0; m_act = nxt; m_slow = s;
    end else begin
      shape(m_act, m_slow, p, h);
      e = (m_ph < h);
      if (m_ph == p - 1) begin m_ph = 0; m_act = nxt; m_slow = s; end
      else m_ph++;
    end
    m_pend = nxt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic burst(input int m, input bit s, input int n, input string tag);
    step(1'b1, m, 1'b0, s, tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b1, s, tag);
    step(1'b0, 0, 1'b0, s, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (carrier_o !== e) begin
          errors++;
          $display("FAIL %s: carrier_o=%b expected %b at %0t", t, carrier_o, e, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    #9;
    checks++;
    if (carrier_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: carrier_o=%b in reset expected 0", carrier_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: idle after reset, then default mode 0 carrier (R2)
    step(1'b0, 0, 1'b0, 1'b0, "R1 idle");
    step(1'b0, 0, 1'b0, 1'b0, "R1 idle");
    for (int i = 0; i < 26; i++) step(1'b0, 0, 1'b1, 1'b0, "R1 R2 default mode 0");
    step(1'b0, 0, 1'b0, 1'b0, "R9 gate off");
    burst(1, 1'b0, 18, "R3 mode 1");
    burst(2, 1'b0, 18, "R4 mode 2");
    burst(3, 1'b0, 24, "R5 mode 3");
    burst(4, 1'b0, 26, "R6 mode 4");
    burst(0, 1'b0, 26, "R2 mode 0");
    // R7 static modes follow the gate
    for (int m = 5; m < 8; m++) begin
      step(1'b1, m, 1'b0, 1'b0, "R7 static write");
      step(1'b0, 0, 1'b1, 1'b0, "R7 static high");
      step(1'b0, 0, 1'b1, 1'b0, "R7 static high");
      step(1'b0, 0, 1'b0, 1'b0, "R7 static low");
      step(1'b0, 0, 1'b1, 1'b0, "R7 static high");
      step(1'b0, 0, 1'b0, 1'b0, "R7 static low");
    end
    // R8 slow option
    burst(3, 1'b1, 180, "R8 slow mode 3");
    burst(1, 1'b1, 130, "R8 slow mode 1");
    burst(4, 1'b1, 100, "R8 slow mode 4");
    step(1'b0, 0, 1'b0, 1'b0, "R8 slow off");
    // R9 gate drop mid-high restarts a full pulse
    step(1'b1, 0, 1'b0, 1'b0, "R9 setup");
    step(1'b0, 0, 1'b1, 1'b0, "R9 first");
    step(1'b0, 0, 1'b1, 1'b0, "R9 first");
    step(1'b0, 0, 1'b0, 1'b0, "R9 drop");
    for (int i = 0; i < 14; i++) step(1'b0, 0, 1'b1, 1'b0, "R9 restart");
    step(1'b0, 0, 1'b0, 1'b0, "R9 drop");
    // R10 mode change mid-period waits for the boundary
    step(1'b1, 1, 1'b0, 1'b0, "R10 setup");
    step(1'b0, 0, 1'b1, 1'b0, "R10 mode 1");
    step(1'b0, 0, 1'b1, 1'b0, "R10 mode 1");
    step(1'b1, 3, 1'b1, 1'b0, "R10 write mid period");
    for (int i = 0; i < 20; i++) step(1'b0, 0, 1'b1, 1'b0, "R10 after change");
    step(1'b1, 5, 1'b1, 1'b0, "R10 write static");
    for (int i = 0; i < 12; i++) step(1'b0, 0, 1'b1, 1'b0, "R10 to static");
    step(1'b1, 2, 1'b1, 1'b0, "R10 static to mode 2");
    for (int i = 0; i < 10; i++) step(1'b0, 0, 1'b1, 1'b0, "R10 mode 2");
    step(1'b0, 0, 1'b0, 1'b0, "R10 end");
    while (exp_q.size() > 0) @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule